// File: doc/BRIEF.md
# Dual-Target Level Interrupt Controller

This block gathers 32 level-sensitive interrupt requests and presents them to two processor targets. Every target owns a pending register and an enable register. A request sets its pending bit in both targets. Each target's enable register then decides whether that pending bit counts toward the target's interrupt line. Setting a source's enable bit in one target and clearing it in the other steers the source to a single processor.

Software reaches the four registers through a small 32-bit register port with an address, a write strobe, write data and read data. A write of ones to a pending register acknowledges those sources. The enable registers are ordinary read/write storage. To quiesce a target, software clears its enable register and then writes all ones to its pending register. Read data is registered and appears one clock after the address.

Top module: `dual_target_irq_ctrl`

## Requirements
- R1: There are 32 sources, and source i owns bit i of every register. A source that is high at a clock edge sets bit i of both targets' pending registers at that edge. The bit stays set after the source drops, until it is acknowledged.
- R2: Byte offsets on `reg_addr` select the registers: 0x00 is the pending register of target 0, 0x04 the enable register of target 0, 0x08 the pending register of target 1 and 0x0C the enable register of target 1. `reg_rdata` is registered. It shows the register addressed at a clock edge as that register stood just before the edge.
- R3: A write to a pending register clears each bit written as 1 and leaves each bit written as 0 unchanged. The other target's pending register is not affected.
- R4: The enable registers are plain read/write registers. A value written to one reads back unchanged.
- R5: `irq_out[t]` is the OR of (pending AND enable) of target t, registered once. It rises on the clock edge after a pending bit and its enable bit are both set. A source enabled only in target t drives only `irq_out[t]`.
- R6: When a source is high in the same cycle as a write of 1 to its pending bit, the source wins and the bit stays set.
- R7: After a write of 0 to a target's enable register, followed by a write of all ones to its pending register while no source is high, both registers read 0 and the target's `irq_out` bit is 0.
- R8: Synchronous active-high `rst` clears all pending bits, all enable bits, `irq_out` and `reg_rdata`.
- R9: A read from an offset other than the four listed returns 0. A write to such an offset changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_req | input | 32 | Level interrupt requests, one per source |
| reg_addr | input | 5 | Register byte offset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| irq_out | output | 2 | One interrupt line per target |

## Verification
The embedded properties assume that `rst` is held high through the first clock edge. The acknowledge-clearing property assumes that no source is high during an acknowledge it judges. The register-port properties assume that `reg_addr` and `reg_we` are driven to known values on every cycle. The bench drives every input on the falling edge, starts with reset asserted and keeps all sources low around the acknowledges that are meant to clear. The one deliberate overlap of a request and an acknowledge is the case that checks the request wins.

// File: rtl/dtic_pkg.sv
package dtic_pkg;
  // byte distance between the register pairs of consecutive targets
  localparam int unsigned TGT_STRIDE = 8;
  // byte offset of the enable register inside a target's pair
  localparam int unsigned EN_OFS     = 4;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_PEND = 2'd1,
    SEL_EN   = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/dtic_regif.sv
module dtic_regif #(
  parameter int unsigned NTGT   = 2,
  parameter int unsigned NSRC   = 32,
  parameter int unsigned ADDR_W = 5
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [ADDR_W-1:0]          addr,
  input  logic                       we,
  input  logic [NTGT-1:0][NSRC-1:0]  pend_vals,
  input  logic [NTGT-1:0][NSRC-1:0]  en_vals,
  output logic [NTGT-1:0]            ack_we,
  output logic [NTGT-1:0]            en_we,
  output logic [NSRC-1:0]            rdata_q
);
  import dtic_pkg::*;

  logic [NTGT-1:0] hit_pend;
  logic [NTGT-1:0] hit_en;
  logic [NSRC-1:0] rd_mux;
  logic            any_hit;

  for (genvar t = 0; t < NTGT; t++) begin : g_dec
    localparam int unsigned PEND_ADDR = t * TGT_STRIDE;
    localparam int unsigned EN_ADDR   = t * TGT_STRIDE + EN_OFS;
    assign hit_pend[t] = (addr == ADDR_W'(PEND_ADDR));
    assign hit_en[t]   = (addr == ADDR_W'(EN_ADDR));
    assign ack_we[t]   = we & hit_pend[t];
    assign en_we[t]    = we & hit_en[t];
  end

  assign any_hit = (|hit_pend) | (|hit_en);

  always_comb begin
    rd_mux = '0;
    for (int t = 0; t < NTGT; t++) begin
      if (hit_pend[t]) rd_mux = rd_mux | pend_vals[t];
      if (hit_en[t])   rd_mux = rd_mux | en_vals[t];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_mux;
  end

  // R2
  one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ack_we, en_we}));

  // R9
  unmapped_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (we && !any_hit) |-> ({ack_we, en_we} == '0));

  // R9
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (rst)
    (!any_hit) |=> (rdata_q == '0));
endmodule

// File: rtl/dtic_target_bank.sv
module dtic_target_bank #(
  parameter int unsigned NSRC = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_req,
  input  logic            ack_we,
  input  logic            en_we,
  input  logic [NSRC-1:0] wdata,
  output logic [NSRC-1:0] pend_q,
  output logic [NSRC-1:0] en_q,
  output logic            irq_q
);
  logic [NSRC-1:0] ack_bits;
  logic [NSRC-1:0] pend_d;
  logic [NSRC-1:0] live;

  assign ack_bits = ack_we ? wdata : '0;
  // a request in the acknowledge cycle overrides the clear
  assign pend_d   = (pend_q & ~ack_bits) | src_req;
  assign live     = pend_q & en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      en_q   <= '0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      if (en_we) en_q <= wdata;
      irq_q <= |live;
    end
  end

  // R1
  src_latch_chk: assert property (@(posedge clk) disable iff (rst)
    (|src_req) |=> ((pend_q & $past(src_req)) == $past(src_req)));

  // R3
  ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_we && src_req == '0) |=> ((pend_q & $past(wdata)) == '0));

  // R4
  en_write_chk: assert property (@(posedge clk) disable iff (rst)
    en_we |=> (en_q == $past(wdata)));

  // R5
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (en_q == '0) |=> !irq_q);

  // R8
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (pend_q == '0 && en_q == '0 && !irq_q));
endmodule

// File: rtl/dual_target_irq_ctrl.sv
module dual_target_irq_ctrl #(
  parameter int unsigned NSRC   = 32,
  parameter int unsigned NTGT   = 2,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   src_req,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [NSRC-1:0]   reg_wdata,
  output logic [NSRC-1:0]   reg_rdata,
  output logic [NTGT-1:0]   irq_out
);
  logic [NTGT-1:0][NSRC-1:0] pend_all;
  logic [NTGT-1:0][NSRC-1:0] en_all;
  logic [NTGT-1:0]           ack_we;
  logic [NTGT-1:0]           en_we;

  dtic_regif #(
    .NTGT   (NTGT),
    .NSRC   (NSRC),
    .ADDR_W (ADDR_W)
  ) u_regif (
    .clk       (clk),
    .rst       (rst),
    .addr      (reg_addr),
    .we        (reg_we),
    .pend_vals (pend_all),
    .en_vals   (en_all),
    .ack_we    (ack_we),
    .en_we     (en_we),
    .rdata_q   (reg_rdata)
  );

  for (genvar t = 0; t < NTGT; t++) begin : g_tgt
    dtic_target_bank #(
      .NSRC (NSRC)
    ) u_bank (
      .clk     (clk),
      .rst     (rst),
      .src_req (src_req),
      .ack_we  (ack_we[t]),
      .en_we   (en_we[t]),
      .wdata   (reg_wdata),
      .pend_q  (pend_all[t]),
      .en_q    (en_all[t]),
      .irq_q   (irq_out[t])
    );
  end

  // R8
  rdata_reset_chk: assert property (@(posedge clk)
    rst |=> (reg_rdata == '0 && irq_out == '0));
endmodule

// File: tb/test_dual_target_irq_ctrl.sv
module test_dual_target_irq_ctrl;
  localparam int CLK_P = 10;
  localparam int NV    = 23;

  typedef struct packed {
    logic        wr;
    logic [4:0]  addr;
    logic [31:0] data;   // write data, or expected read data
    logic [31:0] src;
    logic [3:0]  req;
  } vec_t;

  // R4 R2 R1 R3 R9 R6 vectors; the req field holds the requirement number
  localparam vec_t VECS [NV] = '{
    '{1'b1, 5'h04, 32'h0000_00F0, 32'h0, 4'd4},
    '{1'b0, 5'h04, 32'h0000_00F0, 32'h0, 4'd4},
    '{1'b1, 5'h0C, 32'h0F0F_0000, 32'h0, 4'd4},
    '{1'b0, 5'h0C, 32'h0F0F_0000, 32'h0, 4'd4},
    '{1'b0, 5'h00, 32'h0000_0000, 32'h8000_0001, 4'd2},
    '{1'b0, 5'h00, 32'h8000_0001, 32'h0, 4'd1},
    '{1'b0, 5'h08, 32'h8000_0001, 32'h0, 4'd1},
    '{1'b1, 5'h00, 32'h0000_0001, 32'h0, 4'd3},
    '{1'b0, 5'h00, 32'h8000_0000, 32'h0, 4'd3},
    '{1'b0, 5'h08, 32'h8000_0001, 32'h0, 4'd3},
    '{1'b1, 5'h10, 32'hFFFF_FFFF, 32'h0, 4'd9},
    '{1'b0, 5'h10, 32'h0000_0000, 32'h0, 4'd9},
    '{1'b0, 5'h04, 32'h0000_00F0, 32'h0, 4'd9},
    '{1'b0, 5'h0C, 32'h0F0F_0000, 32'h0, 4'd9},
    '{1'b1, 5'h05, 32'h0000_0000, 32'h0, 4'd9},
    '{1'b0, 5'h04, 32'h0000_00F0, 32'h0, 4'd9},
    '{1'b0, 5'h01, 32'h0000_0000, 32'h0, 4'd9},
    '{1'b1, 5'h08, 32'h8000_0000, 32'h8000_0000, 4'd6},
    '{1'b0, 5'h08, 32'h8000_0001, 32'h0, 4'd6},
    '{1'b1, 5'h00, 32'h0000_0000, 32'h0, 4'd3},
    '{1'b0, 5'h00, 32'h8000_0000, 32'h0, 4'd3},
    '{1'b1, 5'h08, 32'h8000_0001, 32'h0, 4'd3},
    '{1'b0, 5'h08, 32'h0000_0000, 32'h0, 4'd3}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] src_req = '0;
  logic [4:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [1:0]  irq_out;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  dual_target_irq_ctrl i_dual_target_irq_ctrl (
    .clk       (clk),
    .rst       (rst),
    .src_req   (src_req),
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_out   (irq_out)
  );

  // drive one cycle of inputs at a falling edge, return at the next one
  task automatic do_op(input logic wr, input logic [4:0] a,
                       input logic [31:0] d, input logic [31:0] s);
    reg_we    = wr;
    reg_addr  = a;
    reg_wdata = wr ? d : 32'h0;
    src_req   = s;
    @(negedge clk);
    reg_we    = 1'b0;
  endtask

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin : watchdog
    #(CLK_P * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8 irq", {30'h0, irq_out}, 32'h0);
    check("R8 rdata", reg_rdata, 32'h0);
    rst = 1'b0;
    do_op(1'b0, 5'h00, 32'h0, 32'h0);
    check("R8 pend0", reg_rdata, 32'h0);
    do_op(1'b0, 5'h0C, 32'h0, 32'h0);
    check("R8 en1", reg_rdata, 32'h0);

    for (int i = 0; i < NV; i++) begin
      do_op(VECS[i].wr, VECS[i].addr, VECS[i].data, VECS[i].src);
      if (!VECS[i].wr)
        check($sformatf("R%0d vec%0d", VECS[i].req, i), reg_rdata, VECS[i].data);
    end

    // R5 nothing live yet
    check("R5 idle", {30'h0, irq_out}, 32'h0);
    // pulse source 4: enabled in target 0 only
    do_op(1'b0, 5'h00, 32'h0, 32'h0000_0010);
    do_op(1'b0, 5'h00, 32'h0, 32'h0);
    check("R1 pend0 bit4", reg_rdata, 32'h8000_0010);
    check("R5 steer t0", {30'h0, irq_out}, 32'h1);
    // enable source 4 in target 1 as well
    do_op(1'b1, 5'h0C, 32'h0000_0010, 32'h0);
    check("R5 lag", {30'h0, irq_out}, 32'h1);
    do_op(1'b0, 5'h0C, 32'h0, 32'h0);
    check("R5 both", {30'h0, irq_out}, 32'h3);

    // R7 quiesce target 0
    do_op(1'b1, 5'h04, 32'h0, 32'h0);
    do_op(1'b1, 5'h00, 32'hFFFF_FFFF, 32'h0);
    check("R7 irq", {30'h0, irq_out}, 32'h2);
    do_op(1'b0, 5'h00, 32'h0, 32'h0);
    check("R7 pend0", reg_rdata, 32'h0);
    do_op(1'b0, 5'h04, 32'h0, 32'h0);
    check("R7 en0", reg_rdata, 32'h0);
    do_op(1'b0, 5'h08, 32'h0, 32'h0);
    check("R7 pend1 kept", reg_rdata, 32'h0000_0010);

    // R8 reset mid-run
    rst = 1'b1;
    do_op(1'b0, 5'h00, 32'h0, 32'h0);
    rst = 1'b0;
    check("R8 irq after", {30'h0, irq_out}, 32'h0);
    do_op(1'b0, 5'h0C, 32'h0, 32'h0);
    check("R8 en1 after", reg_rdata, 32'h0);
    do_op(1'b0, 5'h08, 32'h0, 32'h0);
    check("R8 pend1 after", reg_rdata, 32'h0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule